// File: doc/BRIEF.md
# Three-Channel Doorbell Mailbox

This block lets processors signal each other through three independent channels, each holding a 32-bit pending word. Software never rewrites a pending word directly. A write to the set view turns on the bits that carry a one, and a write to the clear view turns off the bits that carry a one. Several agents can therefore own disjoint bits of one channel and update them without a read-modify-write sequence. A read of the status view returns the current word. Each channel drives its own interrupt line, which is high while any bit of its word is non-zero.

The same hardware supports two usage styles. In doorbell use, each bit is a separate event, and the line stays up until every event has been acknowledged. In single-word use, a sender places a non-zero 32-bit value through the set view. The receiver reads it and writes the same value to the clear view, which returns the word to zero and drops the line.

Channel 0 accepts only secure accesses, while channels 1 and 2 accept any access. The register bus follows APB with no wait states. An access takes a setup cycle followed by one access cycle (`psel` and `penable` both high). Read data and the error flag are valid during the access cycle.

Top module: `doorbell_mbox`

## Requirements
- R1: While `rst_n` is low, and after it rises, every pending word reads 0 and all `irq` bits are 0.
- R2: A write to the set view of a channel (address channel*0x20 + 0x00) sets each pending bit whose write-data bit is 1 and leaves every other bit unchanged.
- R3: A write to the clear view of a channel (channel*0x20 + 0x04) clears each pending bit whose write-data bit is 1 and leaves every other bit unchanged.
- R4: A read of the status view (channel*0x20 + 0x08) returns the pending word. Reads of the set or clear view, of any other offset, of a misaligned address, or of channel index 3 (0x60 to 0x7F) return 0.
- R5: Writes to the status view, to any other unmapped offset or to channel index 3 change no pending word.
- R6: `irq[c]` equals the OR of channel c's pending word delayed by one clock. A write accepted at clock edge k is visible in status from edge k and on `irq` from edge k+1.
- R7: An access that addresses one channel never changes the pending word of another channel.
- R8: When `nsec` is 1, an access to channel 0 reads 0, leaves its word unchanged and drives `pslverr` high during that access cycle. `pslverr` is 0 for every other access.
- R9: In single-word use, a non-zero value written through set reads back unchanged. Writing the same value to clear returns the word to 0, and the channel's `irq` then falls.
- R10: In doorbell use with disjoint bit groups, `irq` stays high while any group still has a pending bit. It falls only after the last bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus enable, marks the access cycle |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 7 | Byte address; bits 6:5 select the channel, bits 4:0 the offset |
| pwdata | input | 32 | Write data |
| nsec | input | 1 | 1 = non-secure access |
| prdata | output | 32 | Read data, valid in the access cycle |
| pslverr | output | 1 | Error response for a blocked secure access |
| irq | output | 3 | Per-channel interrupt, bit c for channel c |

## Verification
The assertions assume that every bus access follows the APB protocol. A setup cycle with `psel` high and `penable` low comes first, then one access cycle with `penable` high. Address, data, direction and `nsec` hold steady across both cycles, and `penable` is never high without `psel`. The bench drives all of its stimulus through a single transfer task that produces this two-cycle shape, returns to idle between transfers and uses only word-aligned addresses except where it probes the unmapped case.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Byte offsets inside one channel window
  typedef enum logic [4:0] {
    OFS_SET  = 5'h00,
    OFS_CLR  = 5'h04,
    OFS_STAT = 5'h08
  } mbox_ofs_e;

  // Spacing between channel windows is 2**WIN_LSB bytes
  localparam int WIN_LSB = 5;

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int               NUM_CH  = 3,
  parameter int               ADDR_W  = 7,
  parameter logic [NUM_CH-1:0] SEC_MASK = 3'b001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              nsec,
  output logic [NUM_CH-1:0] set_en,
  output logic [NUM_CH-1:0] clr_en,
  output logic [NUM_CH-1:0] rd_sel,
  output logic              sec_err
);

  localparam int BLK_W = ADDR_W - WIN_LSB;

  logic              access;
  logic [BLK_W-1:0]  blk;
  logic [WIN_LSB-1:0] ofs;
  logic              ofs_set;
  logic              ofs_clr;
  logic              ofs_stat;
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] blocked;

  assign access   = psel & penable;
  assign blk      = paddr[ADDR_W-1:WIN_LSB];
  assign ofs      = paddr[WIN_LSB-1:0];
  assign ofs_set  = (ofs == OFS_SET);
  assign ofs_clr  = (ofs == OFS_CLR);
  assign ofs_stat = (ofs == OFS_STAT);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic allowed;
    assign hit[c]     = access & (blk == BLK_W'(c));
    assign blocked[c] = hit[c] & SEC_MASK[c] & nsec;
    assign allowed    = hit[c] & ~blocked[c];
    assign set_en[c]  = allowed &  pwrite & ofs_set;
    assign clr_en[c]  = allowed &  pwrite & ofs_clr;
    assign rd_sel[c]  = allowed & ~pwrite & ofs_stat;

    if (SEC_MASK[c]) begin : g_sec
      // R8: non-secure traffic never reaches a secure channel
      a_r8_sec_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (access && nsec && (blk == BLK_W'(c))) |-> !(set_en[c] || clr_en[c] || rd_sel[c]))
        else $error("non-secure access reached secure channel %0d", c);
    end
  end

  assign sec_err = |blocked;

  // R7: at most one channel strobe of any kind per access
  a_r7_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_en, clr_en, rd_sel}))
    else $error("more than one channel strobe active");

  // R8: error only inside an access cycle
  a_r8_err_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    sec_err |-> (psel && penable && nsec))
    else $error("error raised outside a non-secure access cycle");

endmodule

// File: rtl/mbox_channel.sv
module mbox_channel #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] pend_o,
  output logic              irq_o
);

  logic [DATA_W-1:0] pend_q;
  logic [DATA_W-1:0] pend_d;
  logic              pend_ce;
  logic              irq_q;
  logic              irq_d;

  // next-state for the pending word
  always_comb begin
    pend_d = pend_q;
    if (set_en) pend_d = pend_d | wdata;
    if (clr_en) pend_d = pend_d & ~wdata;
  end

  assign pend_ce = set_en | clr_en;
  assign irq_d   = |pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_ce) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  // R2: written ones appear, other bits keep their value
  a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (((pend_q & $past(wdata)) == $past(wdata)) &&
               ((pend_q & ~$past(wdata)) == ($past(pend_q) & ~$past(wdata)))))
    else $error("set view did not behave as write-one-to-set");

  // R3: written ones vanish, other bits keep their value
  a_r3_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (((pend_q & $past(wdata)) == '0) &&
               ((pend_q & ~$past(wdata)) == ($past(pend_q) & ~$past(wdata)))))
    else $error("clear view did not behave as write-one-to-clear");

  // R5: no strobe, no change
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en || clr_en) |=> $stable(pend_q))
    else $error("pending word changed without a strobe");

  // R6: interrupt rises one cycle after the word turns non-zero
  a_r6_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(pend_q) != '0))
    else $error("interrupt rose without a pending bit");

  // R6: interrupt falls one cycle after the word returns to zero
  a_r6_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> ($past(pend_q) == '0))
    else $error("interrupt fell while bits were pending");

endmodule

// File: rtl/doorbell_mbox.sv
module doorbell_mbox
  import mbox_pkg::*;
#(
  parameter int               NUM_CH   = 3,
  parameter int               DATA_W   = 32,
  parameter int               ADDR_W   = 7,
  parameter logic [NUM_CH-1:0] SEC_MASK = 3'b001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic              nsec,
  output logic [DATA_W-1:0] prdata,
  output logic              pslverr,
  output logic [NUM_CH-1:0] irq
);

  logic [NUM_CH-1:0] set_en;
  logic [NUM_CH-1:0] clr_en;
  logic [NUM_CH-1:0] rd_sel;
  logic [DATA_W-1:0] pend [NUM_CH];

  mbox_decode #(
    .NUM_CH  (NUM_CH),
    .ADDR_W  (ADDR_W),
    .SEC_MASK(SEC_MASK)
  ) u_decode (
    .clk    (clk),
    .rst_n  (rst_n),
    .psel   (psel),
    .penable(penable),
    .pwrite (pwrite),
    .paddr  (paddr),
    .nsec   (nsec),
    .set_en (set_en),
    .clr_en (clr_en),
    .rd_sel (rd_sel),
    .sec_err(pslverr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    mbox_channel #(
      .DATA_W(DATA_W)
    ) u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .set_en(set_en[c]),
      .clr_en(clr_en[c]),
      .wdata (pwdata),
      .pend_o(pend[c]),
      .irq_o (irq[c])
    );
  end

  // status read mux, zero when nothing is selected
  always_comb begin
    prdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_sel[c]) prdata = prdata | pend[c];
    end
  end

  // R4: write cycles and idle cycles carry no read data
  a_r4_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !(psel && penable && !pwrite) |-> (prdata == '0))
    else $error("read data driven outside a read access");

  // R1: reset leaves every line low
  a_r1_reset_irq: assert property (@(posedge clk)
    !rst_n |-> (irq == '0))
    else $error("interrupt high during reset");

endmodule

// File: tb/sim_doorbell_mbox.sv
module sim_doorbell_mbox;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [6:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic        nsec = 1'b0;
  logic [31:0] prdata;
  logic        pslverr;
  logic [2:0]  irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  doorbell_mbox u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .nsec(nsec), .prdata(prdata),
    .pslverr(pslverr), .irq(irq)
  );

  // behavioural reference: pending words and delayed interrupt flags
  logic [31:0] m_pend [3];
  logic [2:0]  m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 3; c++) m_pend[c] <= 32'h0;
      m_irq <= 3'b000;
    end else begin
      for (int c = 0; c < 3; c++) m_irq[c] <= (m_pend[c] != 32'h0);
      if (psel && penable && pwrite) begin
        int b;
        b = int'(paddr) / 32;
        if (b < 3 && !(b == 0 && nsec)) begin
          if (paddr[4:0] == 5'h00) m_pend[b] <= m_pend[b] | pwdata;
          if (paddr[4:0] == 5'h04) m_pend[b] <= m_pend[b] & ~pwdata;
        end
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [6:0] a, input logic ns);
    int b;
    b = int'(a) / 32;
    if (b >= 3 || (b == 0 && ns) || a[4:0] != 5'h08) return 32'h0;
    return m_pend[b];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // interrupt compared against the reference on every clock (R6)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(irq === m_irq, "R6 irq vs model", {29'h0, irq}, {29'h0, m_irq});
    end
  end

  task automatic xfer(input logic wr, input logic [6:0] a, input logic [31:0] d,
                      input logic ns, output logic [31:0] rd, output logic er);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d; nsec = ns;
    @(negedge clk);
    penable = 1'b1;
    #(CLK_P/4);
    rd = prdata;
    er = pslverr;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr_chk(input logic [6:0] a, input logic [31:0] d, input logic ns, input string req);
    logic [31:0] rd;
    logic er;
    logic exp_er;
    exp_er = (a < 7'h20) && ns;
    xfer(1'b1, a, d, ns, rd, er);
    check(er === exp_er, req, {31'h0, er}, {31'h0, exp_er});
  endtask

  task automatic rd_chk(input logic [6:0] a, input logic ns, input string req);
    logic [31:0] rd;
    logic [31:0] ex;
    logic er;
    logic exp_er;
    exp_er = (a < 7'h20) && ns;
    ex = exp_rd(a, ns);
    xfer(1'b0, a, 32'h0, ns, rd, er);
    check(rd === ex, req, rd, ex);
    check(er === exp_er, {req, " err"}, {31'h0, er}, {31'h0, exp_er});
  endtask

  task automatic irq_chk(input int c, input logic v, input string req);
    @(negedge clk); @(negedge clk);
    #1;
    check(irq[c] === v, req, {31'h0, irq[c]}, {31'h0, v});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(irq === 3'b000, "R1 irq in reset", {29'h0, irq}, 32'h0);
    rst_n = 1'b1;
    rd_chk(7'h08, 1'b0, "R1 ch0 status");
    rd_chk(7'h28, 1'b1, "R1 ch1 status");
    rd_chk(7'h48, 1'b1, "R1 ch2 status");

    // R2 set view
    wr_chk(7'h20, 32'h0000_00F0, 1'b1, "R2 set err");
    rd_chk(7'h28, 1'b1, "R2 first set");
    wr_chk(7'h20, 32'h0F00_0000, 1'b1, "R2 set err");
    rd_chk(7'h28, 1'b1, "R2 merge set");
    // R3 clear view
    wr_chk(7'h24, 32'h0000_0030, 1'b1, "R3 clr err");
    rd_chk(7'h28, 1'b1, "R3 partial clear");
    // R4 zero reads
    rd_chk(7'h20, 1'b1, "R4 set view read");
    rd_chk(7'h24, 1'b1, "R4 clr view read");
    rd_chk(7'h2C, 1'b1, "R4 spare offset");
    rd_chk(7'h29, 1'b1, "R4 misaligned");
    rd_chk(7'h68, 1'b0, "R4 channel 3");
    // R5 ignored writes
    wr_chk(7'h28, 32'hFFFF_FFFF, 1'b1, "R5 status write");
    rd_chk(7'h28, 1'b1, "R5 status unchanged");
    wr_chk(7'h60, 32'hFFFF_FFFF, 1'b0, "R5 channel 3 write");
    wr_chk(7'h21, 32'hFFFF_FFFF, 1'b1, "R5 misaligned write");
    rd_chk(7'h28, 1'b1, "R5 ch1 unchanged");
    // R7 isolation
    rd_chk(7'h48, 1'b1, "R7 ch2 untouched");
    rd_chk(7'h08, 1'b0, "R7 ch0 untouched");
    // R8 secure channel
    wr_chk(7'h00, 32'h0000_00FF, 1'b1, "R8 ns write err");
    rd_chk(7'h08, 1'b0, "R8 ns write ignored");
    wr_chk(7'h00, 32'h0000_0001, 1'b0, "R8 secure write");
    rd_chk(7'h08, 1'b0, "R8 secure read");
    rd_chk(7'h08, 1'b1, "R8 ns read zero");
    irq_chk(0, 1'b1, "R8 ch0 irq");
    wr_chk(7'h04, 32'h0000_0001, 1'b1, "R8 ns clear err");
    rd_chk(7'h08, 1'b0, "R8 ns clear ignored");
    wr_chk(7'h04, 32'h0000_0001, 1'b0, "R8 secure clear");
    irq_chk(0, 1'b0, "R8 ch0 irq low");
    // R9 single-word use on ch2
    wr_chk(7'h40, 32'hDEAD_BEEF, 1'b1, "R9 send");
    rd_chk(7'h48, 1'b1, "R9 receive");
    irq_chk(2, 1'b1, "R9 irq up");
    wr_chk(7'h44, 32'hDEAD_BEEF, 1'b1, "R9 ack");
    rd_chk(7'h48, 1'b1, "R9 word zero");
    irq_chk(2, 1'b0, "R9 irq down");
    // R10 doorbell groups on ch1
    wr_chk(7'h24, 32'hFFFF_FFFF, 1'b1, "R10 flush");
    irq_chk(1, 1'b0, "R10 idle");
    wr_chk(7'h20, 32'h0000_0001, 1'b1, "R10 group A");
    wr_chk(7'h20, 32'h0000_0100, 1'b0, "R10 group B");
    wr_chk(7'h24, 32'h0000_0001, 1'b1, "R10 ack A");
    irq_chk(1, 1'b1, "R10 B still pending");
    rd_chk(7'h28, 1'b1, "R10 only B left");
    wr_chk(7'h24, 32'h0000_0100, 1'b0, "R10 ack B");
    irq_chk(1, 1'b0, "R10 all acked");

    // R1 asynchronous reset with bits pending
    wr_chk(7'h40, 32'h0000_0005, 1'b1, "R1 preload");
    irq_chk(2, 1'b1, "R1 preload irq");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(irq === 3'b000, "R1 irq cleared", {29'h0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    rd_chk(7'h48, 1'b1, "R1 word cleared");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule